// File: doc/BRIEF.md
# Deferred Write-Back Register File

This block is the general-purpose register storage of a small multi-cycle processor datapath. It offers two read ports feeding the two operand buses and one write port. A result is not written in the cycle that produces it: the result latch captures the ALU output or the load data at the end of the execute cycle. The register write then happens during the first fetch cycle of the next instruction, so the write overlaps that fetch.

The destination index is latched together with the result. The instruction fields may change while the next instruction word arrives without moving the write target. Port1 is addressed by the r1 field. Port2 is addressed through a two-way selector that takes the r2 field for register/register operations and the r3 field when a store needs the source register. Each read port drives zero onto its bus unless enabled. A read that hits the register being written in the same cycle returns the new value.

Top module: `dwb_regfile`

## Requirements
- R1: After reset every register reads zero, wr_en_o is low and wr_addr_o and wr_data_o are zero.
- R2: A cycle with res_latch_en_i high captures res_data_i into wr_data_o and instr_r3_i into wr_addr_o at its closing edge. In the next cycle with fetch0_i high, wr_en_o is high and the register is updated at the end of that cycle.
- R3: wr_en_o is high only while fetch0_i is high and a captured result is pending. The pending state clears at the edge that ends the write cycle, so a later fetch0_i without a new capture does not raise wr_en_o.
- R4: wr_addr_o changes only at an edge where res_latch_en_i was high; changes of instr_r3_i at other times do not move the write target.
- R5: With port1_en_i high, op1_o shows the register addressed by instr_r1_i.
- R6: With port2_en_i high, op2_o shows the register addressed by instr_r2_i when port2_sel_r3_i is 0, and by instr_r3_i when it is 1.
- R7: A read port whose enable is low drives all zeros on its operand output.
- R8: While wr_en_o is high, an enabled read port whose address equals wr_addr_o returns wr_data_o.
- R9: A captured result stays pending through any number of cycles without fetch0_i and is written at the first fetch0_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_r1_i | input | AW | r1 field: port1 address |
| instr_r2_i | input | AW | r2 field: port2 address when selector is 0 |
| instr_r3_i | input | AW | r3 field: destination, or port2 address for stores |
| port1_en_i | input | 1 | Drive port1 onto op1_o |
| port2_en_i | input | 1 | Drive port2 onto op2_o |
| port2_sel_r3_i | input | 1 | Port2 address select: 0 = r2, 1 = r3 |
| res_latch_en_i | input | 1 | Capture result, destination and set pending |
| res_data_i | input | DW | ALU result or load data |
| fetch0_i | input | 1 | First fetch state of the sequencer |
| op1_o | output | DW | Operand bus 1 |
| op2_o | output | DW | Operand bus 2 |
| wr_en_o | output | 1 | Port3 write enable |
| wr_addr_o | output | AW | Latched destination index |
| wr_data_o | output | DW | Latched result |

## Verification
The assertions assume the sequencer never raises res_latch_en_i in the same cycle as a write. They therefore read one asserted write cycle without a fresh capture as the end of the pending state. The bench keeps to this order: it issues the capture in an execute cycle, then one fetch0 cycle, then a second fetch cycle. Stall cycles are idle cycles with no capture. All enables are low whenever the bench moves an instruction field that is not under test.

// File: rtl/dwb_pkg.sv
`timescale 1ns/1ps
package dwb_pkg;
  typedef enum logic {
    P2_SRC_R2 = 1'b0,
    P2_SRC_R3 = 1'b1
  } p2_src_e;
  localparam int unsigned NUM_RD_PORTS = 2;
endpackage

// File: rtl/dwb_wb_ctrl.sv
`timescale 1ns/1ps
module dwb_wb_ctrl #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] cap_data_i,
  input  logic [AW-1:0] cap_addr_i,
  input  logic          fetch0_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          pend_q;
  logic [AW-1:0] dst_q;
  logic [DW-1:0] res_q;

  assign wr_en_o   = pend_q & fetch0_i;
  assign wr_addr_o = dst_q;
  assign wr_data_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dst_q  <= '0;
      res_q  <= '0;
    end else if (cap_i) begin
      pend_q <= 1'b1;
      dst_q  <= cap_addr_i;
      res_q  <= cap_data_i;
    end else if (wr_en_o) begin
      // write commits at end of fetch0; flag clear entering fetch1
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dwb_reg_array.sv
`timescale 1ns/1ps
module dwb_reg_array #(
  parameter int unsigned NREG = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned DW   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NREG-1:0][DW-1:0]  mem_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_o[g] <= '0;
      else if (we_i && waddr_i == AW'(g))            mem_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/dwb_read_port.sv
`timescale 1ns/1ps
module dwb_read_port #(
  parameter int unsigned NREG = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned DW   = 32
) (
  input  logic                    en_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [NREG-1:0][DW-1:0] mem_i,
  input  logic                    byp_en_i,
  input  logic [AW-1:0]           byp_addr_i,
  input  logic [DW-1:0]           byp_data_i,
  output logic [DW-1:0]           data_o
);
  always_comb begin
    if (!en_i)                                  data_o = '0;
    else if (byp_en_i && addr_i == byp_addr_i)  data_o = byp_data_i;
    else                                        data_o = mem_i[addr_i];
  end
endmodule

// File: rtl/dwb_regfile.sv
`timescale 1ns/1ps
module dwb_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] instr_r1_i,
  input  logic [AW-1:0] instr_r2_i,
  input  logic [AW-1:0] instr_r3_i,
  input  logic          port1_en_i,
  input  logic          port2_en_i,
  input  logic          port2_sel_r3_i,
  input  logic          res_latch_en_i,
  input  logic [DW-1:0] res_data_i,
  input  logic          fetch0_i,
  output logic [DW-1:0] op1_o,
  output logic [DW-1:0] op2_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  import dwb_pkg::*;

  logic [NREG-1:0][DW-1:0] mem;
  logic [NUM_RD_PORTS-1:0][AW-1:0] rd_addr;
  logic [NUM_RD_PORTS-1:0]         rd_en;
  logic [NUM_RD_PORTS-1:0][DW-1:0] rd_data;
  p2_src_e p2_src;

  assign p2_src     = p2_src_e'(port2_sel_r3_i);
  assign rd_addr[0] = instr_r1_i;
  assign rd_addr[1] = (p2_src == P2_SRC_R3) ? instr_r3_i : instr_r2_i;
  assign rd_en[0]   = port1_en_i;
  assign rd_en[1]   = port2_en_i;

  dwb_wb_ctrl #(.AW(AW), .DW(DW)) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (res_latch_en_i),
    .cap_data_i (res_data_i),
    .cap_addr_i (instr_r3_i),
    .fetch0_i   (fetch0_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  dwb_reg_array #(.NREG(NREG), .AW(AW), .DW(DW)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_o),
    .waddr_i (wr_addr_o),
    .wdata_i (wr_data_o),
    .mem_o   (mem)
  );

  for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_rd
    dwb_read_port #(.NREG(NREG), .AW(AW), .DW(DW)) u_rd (
      .en_i       (rd_en[p]),
      .addr_i     (rd_addr[p]),
      .mem_i      (mem),
      .byp_en_i   (wr_en_o),
      .byp_addr_i (wr_addr_o),
      .byp_data_i (wr_data_o),
      .data_o     (rd_data[p])
    );
  end

  assign op1_o = rd_data[0];
  assign op2_o = rd_data[1];
endmodule

// File: rtl/dwb_regfile_chk.sv
`timescale 1ns/1ps
module dwb_regfile_chk #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] instr_r1_i,
  input logic [AW-1:0] instr_r3_i,
  input logic          port1_en_i,
  input logic          port2_en_i,
  input logic          res_latch_en_i,
  input logic [DW-1:0] res_data_i,
  input logic          fetch0_i,
  input logic [DW-1:0] op1_o,
  input logic [DW-1:0] op2_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o
);
  // R2
  cap_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_latch_en_i |=> (wr_addr_o == $past(instr_r3_i) && wr_data_o == $past(res_data_i)));
  // R2
  cap_then_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_latch_en_i ##1 fetch0_i |-> wr_en_o);
  // R3
  write_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !res_latch_en_i) |=> !wr_en_o);
  // R3
  write_in_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> fetch0_i);
  // R4
  dest_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_latch_en_i |=> $stable(wr_addr_o));
  // R7
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!port1_en_i -> op1_o == '0) && (!port2_en_i -> op2_o == '0)));
  // R8
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && port1_en_i && instr_r1_i == wr_addr_o) |-> op1_o == wr_data_o);
endmodule

bind dwb_regfile dwb_regfile_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .instr_r1_i     (instr_r1_i),
  .instr_r3_i     (instr_r3_i),
  .port1_en_i     (port1_en_i),
  .port2_en_i     (port2_en_i),
  .res_latch_en_i (res_latch_en_i),
  .res_data_i     (res_data_i),
  .fetch0_i       (fetch0_i),
  .op1_o          (op1_o),
  .op2_o          (op2_o),
  .wr_en_o        (wr_en_o),
  .wr_addr_o      (wr_addr_o),
  .wr_data_o      (wr_data_o)
);

// File: tb/dwb_regfile_test.sv
`timescale 1ns/1ps
module dwb_regfile_test;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int AW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] r1 = '0, r2 = '0, r3 = '0;
  logic          p1_en = 1'b0, p2_en = 1'b0, p2_sel = 1'b0;
  logic          cap = 1'b0, f0 = 1'b0;
  logic [DW-1:0] res = '0;
  logic [DW-1:0] op1, op2, wdata;
  logic          wen;
  logic [AW-1:0] waddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] model [NREG];

  always #5 clk = ~clk;

  dwb_regfile #(.NREG(NREG), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_r1_i(r1), .instr_r2_i(r2), .instr_r3_i(r3),
    .port1_en_i(p1_en), .port2_en_i(p2_en), .port2_sel_r3_i(p2_sel),
    .res_latch_en_i(cap), .res_data_i(res), .fetch0_i(f0),
    .op1_o(op1), .op2_o(op2), .wr_en_o(wen), .wr_addr_o(waddr), .wr_data_o(wdata)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    cap = 0; f0 = 0; p1_en = 0; p2_en = 0; p2_sel = 0;
  endtask

  function automatic logic [DW-1:0] rd1(logic [AW-1:0] a);
    return model[a];
  endfunction

  task automatic read_p1(input logic [AW-1:0] a, output logic [DW-1:0] v);
    r1 = a; p1_en = 1; #1; v = op1; p1_en = 0;
  endtask

  // execute capture, fetch0 write, fetch1
  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    idle(); cap = 1; r3 = a; res = d; tick();
    cap = 0; f0 = 1; r3 = ~a; res = ~d; tick();
    f0 = 0; tick();
    model[a] = d;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 wr_en", {31'b0, wen}, 0);
    check("R1 wr_addr", {27'b0, waddr}, 0);
    check("R1 wr_data", wdata, 0);
    for (int i = 0; i < NREG; i += 7) begin
      read_p1(AW'(i), v);
      check("R1 reg zero", v, 0);
    end
  endtask

  task automatic t_timing();
    idle(); cap = 1; r3 = 5'd9; res = 32'hA5A5_0009; #1;
    check("R3 no wr_en in capture", {31'b0, wen}, 0);
    tick();
    cap = 0; r3 = 5'd20; #1;
    check("R2 wr_addr latched", {27'b0, waddr}, 9);
    check("R2 wr_data latched", wdata, 32'hA5A5_0009);
    check("R3 no wr_en before fetch0", {31'b0, wen}, 0);
    f0 = 1; r3 = 5'd21; #1;
    check("R2 wr_en in fetch0", {31'b0, wen}, 1);
    check("R4 addr held despite r3", {27'b0, waddr}, 9);
    tick();
    f0 = 0; #1;
    check("R3 wr_en low in fetch1", {31'b0, wen}, 0);
    model[9] = 32'hA5A5_0009;
    tick();
    f0 = 1; #1;
    check("R3 no second write", {31'b0, wen}, 0);
    tick(); idle();
    begin
      logic [DW-1:0] v;
      read_p1(5'd9, v);
      check("R2 reg updated", v, model[9]);
      read_p1(5'd21, v);
      check("R4 r3 change not written", v, model[21]);
      read_p1(5'd20, v);
      check("R4 r3 change not written", v, model[20]);
    end
  endtask

  task automatic t_stall();
    logic [DW-1:0] v;
    idle(); cap = 1; r3 = 5'd3; res = 32'h0000_3333; tick();
    cap = 0;
    for (int i = 0; i < 4; i++) begin
      r3 = AW'(i + 10); tick();
      check("R9 pending no write in stall", {31'b0, wen}, 0);
    end
    f0 = 1; #1;
    check("R9 write at first fetch0", {31'b0, wen}, 1);
    check("R9 addr kept", {27'b0, waddr}, 3);
    tick(); idle(); tick();
    model[3] = 32'h0000_3333;
    read_p1(5'd3, v);
    check("R9 value landed", v, 32'h0000_3333);
  endtask

  task automatic t_ports();
    logic [DW-1:0] v;
    for (int i = 0; i < 6; i++) do_write(AW'(i * 5 + 1), 32'hC0DE_0000 + 32'(i * 5 + 1));
    for (int i = 0; i < 6; i++) begin
      read_p1(AW'(i * 5 + 1), v);
      check("R5 port1 read", v, model[i * 5 + 1]);
    end
    idle(); r2 = 5'd6; r3 = 5'd26; p2_en = 1; p2_sel = 0; #1;
    check("R6 port2 selects r2", op2, model[6]);
    p2_sel = 1; #1;
    check("R6 port2 selects r3", op2, model[26]);
    r1 = 5'd11; p1_en = 1; #1;
    check("R5 port1 concurrent", op1, model[11]);
    check("R6 port2 concurrent", op2, model[26]);
    idle();
  endtask

  task automatic t_disabled();
    idle(); r1 = 5'd11; r2 = 5'd16; r3 = 5'd21; p2_sel = 1; #1;
    check("R7 port1 disabled zero", op1, 0);
    check("R7 port2 disabled zero", op2, 0);
    p2_sel = 0; #1;
    check("R7 port2 disabled zero r2", op2, 0);
  endtask

  task automatic t_bypass();
    idle(); cap = 1; r3 = 5'd16; res = 32'hFEED_0016; tick();
    cap = 0; f0 = 1; r3 = 5'd2;
    r1 = 5'd16; p1_en = 1; r2 = 5'd16; p2_en = 1; p2_sel = 0; #1;
    check("R8 port1 bypass", op1, 32'hFEED_0016);
    check("R8 port2 bypass", op2, 32'hFEED_0016);
    r2 = 5'd21; #1;
    check("R8 no bypass other addr", op2, model[21]);
    tick(); idle();
    model[16] = 32'hFEED_0016;
    tick();
    r1 = 5'd16; p1_en = 1; #1;
    check("R8 value stored", op1, model[16]);
    idle();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    #23 rst_n = 1'b1;
    tick();
    t_reset();
    t_timing();
    t_stall();
    t_ports();
    t_disabled();
    t_bypass();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule